// File: doc/BRIEF.md
# Gated Fractional Reference Clock Bank

Four independent clock-enable generators sit behind one 32-bit control word. Each generator turns a single fast input clock into a stream of one-cycle enable strobes whose long-run rate is the input rate multiplied by 18 and divided by a per-channel divisor between 18 and 35. A full divisor of 18 gives a strobe on every cycle. A divisor of 35 gives a strobe on a little over half the cycles. Each channel also has a stop bit that parks it.

Software reaches the control word through a small write port with three views. A plain write replaces the word. A set write ORs its data into the word. A clear write removes the bits that are 1 in its data. With the set and clear views, one channel can be started or stopped without touching the other three. The word is always visible on the read bus. Downstream logic uses each strobe as a clock enable in the input clock domain.

Top module: `fracref_bank`

## Requirements
- R1: After reset the control word reads 0x92929292. In every byte the stop bit is 1, bit 6 is 0 and the divisor field is 18. All four strobes are low.
- R2: A write with view 0 (plain) replaces the whole control word with the write data. The new value is readable on the next cycle.
- R3: A write with view 1 (set) ORs the write data into the control word and leaves the other bits unchanged.
- R4: A write with view 2 (clear) forces to 0 every bit where the write data is 1 and leaves the other bits unchanged.
- R5: A write with view 3 leaves the control word unchanged.
- R6: Channel n owns byte n (bits 8n+7..8n). While its stop bit (bit 8n+7) is 1, its strobe stays low and its accumulator holds its value.
- R7: Channel n's divisor F is bits 8n+5..8n. Over any window of N cycles in which a running channel's settings are constant, the number of strobes C satisfies 18N - F < C*F < 18N + F.
- R8: A running channel with F = 18 strobes on every cycle.
- R9: A divisor field below 18, including 0, behaves as 18. A divisor field above 35 behaves as 35.
- R10: Bit 6 of each byte reads back as written and has no effect on the strobe.
- R11: The four channels run independently. Each follows only its own byte.
- R12: Timing. Suppose a write that starts a channel with F = 18 is taken at clock edge k. Then the channel's strobe is low after edge k and high after edge k+1.
- R13: A divisor change takes effect without a burst. On the next cycle the accumulator is reduced modulo the new divisor, so it always stays below 35.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_we | input | 1 | Write strobe for the control word |
| bus_view | input | 2 | Write view: 0 plain, 1 set, 2 clear, 3 no effect |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Current control word |
| tick_o | output | 4 | Per-channel one-cycle enable strobe, bit n for channel n |

## Verification
The bench sweeps random divisor fields, including illegal values of 0 to 17 and 36 to 63, over windows of 1500 cycles. A block that did not clamp the divisor would then run faster than the input allows, or stall completely. Random reserved bits check that bit 6 does not leak into the divisor. Divisors are changed while channels run, with no reset in between. A block that failed to reduce the accumulator modulo the new divisor would break the strobe count bound. Set and clear writes aimed at one lane check that the other lanes keep their state and their strobe rates. A directed start with divisor 18 pins the exact strobe latency.

// File: rtl/fracref_pkg.sv
package fracref_pkg;
  localparam int unsigned NCH      = 4;
  localparam int unsigned LANE_W   = 8;
  localparam int unsigned FRAC_W   = 6;
  localparam int unsigned NUMER    = 18;
  localparam int unsigned FRAC_MIN = 18;
  localparam int unsigned FRAC_MAX = 35;

  typedef enum logic [1:0] {
    VIEW_PLAIN = 2'd0,
    VIEW_SET   = 2'd1,
    VIEW_CLR   = 2'd2,
    VIEW_NONE  = 2'd3
  } view_e;
endpackage

// File: rtl/fracref_rst_sync.sv
module fracref_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fracref_ctrl_reg.sv
module fracref_ctrl_reg
  import fracref_pkg::*;
#(
  parameter int unsigned      WIDTH   = 32,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [1:0]       view_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] word_o
);
  logic [WIDTH-1:0] word_q;
  logic [WIDTH-1:0] word_d;
  logic             word_en;

  always_comb begin
    word_en = we_i && (view_i != VIEW_NONE);
    unique case (view_i)
      VIEW_PLAIN: word_d = wdata_i;
      VIEW_SET:   word_d = word_q | wdata_i;
      VIEW_CLR:   word_d = word_q & ~wdata_i;
      default:    word_d = word_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       word_q <= RST_VAL;
    else if (word_en) word_q <= word_d;
  end

  assign word_o = word_q;

  // R2
  plain_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && view_i == VIEW_PLAIN) |=> (word_o == $past(wdata_i)));
  // R3
  set_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && view_i == VIEW_SET) |=> ((word_o & $past(wdata_i)) == $past(wdata_i)));
  // R4
  clr_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && view_i == VIEW_CLR) |=> ((word_o & $past(wdata_i)) == '0));
  // R5
  idle_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_i || view_i == VIEW_NONE) |=> $stable(word_o));
endmodule

// File: rtl/fracref_chan.sv
module fracref_chan #(
  parameter int unsigned FW   = 6,
  parameter int unsigned NUM  = 18,
  parameter int unsigned FMIN = 18,
  parameter int unsigned FMAX = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stop_i,
  input  logic [FW-1:0] frac_i,
  output logic          tick_o
);
  localparam int unsigned SW = FW + 1;
  localparam logic [SW-1:0] NUM_V = SW'(NUM);
  localparam logic [SW-1:0] MIN_V = SW'(FMIN);
  localparam logic [SW-1:0] MAX_V = SW'(FMAX);

  logic [SW-1:0] div_eff;
  logic [SW-1:0] acc_red;
  logic [SW-1:0] acc_sum;
  logic          hit;
  logic [FW-1:0] acc_q, acc_d;
  logic          tick_q, tick_d;

  always_comb begin
    div_eff = {1'b0, frac_i};
    if (div_eff < MIN_V)      div_eff = MIN_V;
    else if (div_eff > MAX_V) div_eff = MAX_V;
    acc_red = {1'b0, acc_q};
    if (acc_red >= div_eff) acc_red = acc_red - div_eff;
    acc_sum = acc_red + NUM_V;
    hit     = (acc_sum >= div_eff);
    if (stop_i)   acc_d = acc_q;
    else if (hit) acc_d = FW'(acc_sum - div_eff);
    else          acc_d = FW'(acc_sum);
    tick_d = !stop_i && hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_q <= tick_d;
    end
  end

  assign tick_o = tick_q;

  // R6
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_i |=> (!tick_o && $stable(acc_q)));
  // R8
  full_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stop_i && frac_i <= FW'(FMIN)) |=> tick_o);
  // R13
  acc_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, acc_q} < MAX_V));
endmodule

// File: rtl/fracref_bank.sv
module fracref_bank
  import fracref_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_we,
  input  logic [1:0]          bus_view,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic [NCH-1:0]      tick_o
);
  localparam int unsigned REG_W = NCH * LANE_W;
  localparam logic [LANE_W-1:0] RST_LANE =
    {1'b1, {(LANE_W-FRAC_W-1){1'b0}}, FRAC_W'(FRAC_MIN)};
  localparam logic [REG_W-1:0] RST_WORD = {NCH{RST_LANE}};

  logic             rst_n_int;
  logic [REG_W-1:0] ctrl_word;

  fracref_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  fracref_ctrl_reg #(.WIDTH(REG_W), .RST_VAL(RST_WORD)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .we_i    (bus_we),
    .view_i  (bus_view),
    .wdata_i (bus_wdata),
    .word_o  (ctrl_word)
  );

  assign bus_rdata = ctrl_word;

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    fracref_chan #(
      .FW(FRAC_W), .NUM(NUMER), .FMIN(FRAC_MIN), .FMAX(FRAC_MAX)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .stop_i (ctrl_word[n*LANE_W + LANE_W - 1]),
      .frac_i (ctrl_word[n*LANE_W +: FRAC_W]),
      .tick_o (tick_o[n])
    );
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n_int |-> (tick_o == '0));
endmodule

// File: tb/fracref_bank_tb.sv
module fracref_bank_tb;
  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [1:0]  bus_view;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  tick_o;

  int checks = 0;
  int fails  = 0;
  int seed   = 32'h5eed_1234;
  int cnt [4];

  fracref_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_view(bus_view),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_o(tick_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int eff_div(input logic [5:0] raw);
    if (raw < 18) return 18;
    if (raw > 35) return 35;
    return int'(raw);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] view, input logic [31:0] data);
    bus_we = 1'b1; bus_view = view; bus_wdata = data;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic count_window(input int n);
    for (int c = 0; c < 4; c++) cnt[c] = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < 4; c++) if (tick_o[c]) cnt[c]++;
    end
  endtask

  task automatic check_rates(input logic [31:0] word, input int n, input string req);
    for (int c = 0; c < 4; c++) begin
      if (word[8*c+7]) begin
        check(cnt[c] == 0, "R6", cnt[c], 0);
      end else begin
        int f = eff_div(word[8*c +: 6]);
        longint lo = 18*n - f;
        longint hi = 18*n + f;
        longint cf = longint'(cnt[c]) * f;
        check(cf > lo && cf < hi, req, cnt[c], (18*n)/f);
      end
    end
  endtask

  initial begin
    #3_000_000;
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] word, mask;
    void'($urandom(seed));
    rst_n = 1'b0; bus_we = 1'b0; bus_view = 2'd0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check(bus_rdata == 32'h9292_9292, "R1", bus_rdata, 32'h9292_9292);
    check(tick_o == 4'h0, "R1", tick_o, 0);

    // R12 latency: clear stop of channel 0 (divisor 18)
    bus_we = 1'b1; bus_view = 2'd2; bus_wdata = 32'h0000_0080;
    @(posedge clk); #1; bus_we = 1'b0;
    check(tick_o[0] == 1'b0, "R12", tick_o[0], 0);
    @(posedge clk); #1;
    check(tick_o[0] == 1'b1, "R12", tick_o[0], 1);
    @(negedge clk);
    // R8 full rate, R11 others stay stopped
    count_window(200);
    check(cnt[0] == 200, "R8", cnt[0], 200);
    check(cnt[1] + cnt[2] + cnt[3] == 0, "R11", cnt[1] + cnt[2] + cnt[3], 0);

    // R2 plain write
    bus_write(2'd0, 32'h2363_1423);
    check(bus_rdata == 32'h2363_1423, "R2", bus_rdata, 32'h2363_1423);
    // R5 view 3 ignored
    bus_write(2'd3, 32'hFFFF_FFFF);
    check(bus_rdata == 32'h2363_1423, "R5", bus_rdata, 32'h2363_1423);
    // R3 set
    bus_write(2'd1, 32'h8000_0000);
    check(bus_rdata == 32'hA363_1423, "R3", bus_rdata, 32'hA363_1423);
    // R4 clear
    bus_write(2'd2, 32'h2000_0003);
    check(bus_rdata == 32'h8363_1420, "R4", bus_rdata, 32'h8363_1420);

    // R9 clamp: lane0 0 -> 18, lane1 63 -> 35, lane2 17 -> 18, lane3 36 -> 35
    bus_write(2'd0, 32'h2411_3F00);
    @(negedge clk);
    count_window(1400);
    check_rates(32'h2411_3F00, 1400, "R9");

    // R10 reserved bit 6 set on every lane, divisor 35 / 20 / 27 / 18
    bus_write(2'd0, 32'h525B_5463);
    check(bus_rdata == 32'h525B_5463, "R10", bus_rdata, 32'h525B_5463);
    @(negedge clk);
    count_window(1400);
    check_rates(32'h525B_5463, 1400, "R10");

    // R7 / R13 random divisor changes without reset
    for (int t = 0; t < 14; t++) begin
      word = $urandom();
      bus_write(2'd0, word);
      @(negedge clk);
      count_window(1500);
      check_rates(word, 1500, (t % 2 == 0) ? "R7" : "R13");
    end

    // R11 stop one lane via set, others keep their rate
    word = 32'h2319_1C22;
    bus_write(2'd0, word);
    mask = 32'h0000_8000;
    bus_write(2'd1, mask);
    word = word | mask;
    check(bus_rdata == word, "R11", bus_rdata, word);
    @(negedge clk);
    count_window(1500);
    check_rates(word, 1500, "R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule